// File: doc/BRIEF.md
# Valid-Gated Transposed FIR Filter

This block is a 15-tap finite impulse response filter for signed 32-bit samples. A sample is taken in only on a clock edge where its valid strobe is high. On that edge the sample is multiplied by all fifteen coefficients in parallel. The products go into a chain of registered partial sums. Each register adds one product to the sum held in its neighbour, so the longest path is one multiply followed by one add.

The fifteen signed 8-bit coefficients come in on one flat packed bus. They may change while the filter runs. The filtered result and its valid strobe appear one cycle after the sample that produced them. On cycles with no valid input the whole filter is frozen, so any spacing of samples in time gives the same output sequence. The block has no warm-up phase: history before the first sample counts as zero.

Top module: `xpose_fir`

## Requirements
- R1: A synchronous active-high reset sets the output sample and output valid to zero and clears all filter history. The first accepted sample after reset therefore produces coef[0]·x.
- R2: For coefficients held constant, the output for accepted sample n is the low 32 bits of sum over k=0..14 of coef[k]·x[n−k]. coef[k] is bits 8k+7..8k of the coefficient bus, and coefficient 0 weights the newest sample.
- R3: The output valid is high in exactly the cycle after each cycle where input valid is high, and low otherwise.
- R4: On a cycle with input valid low, the input sample has no effect, no filter state changes, and the output sample keeps its previous value.
- R5: There is no start-up latency: the first accepted sample already gives a valid output, with earlier samples taken as zero.
- R6: Coefficients and samples are two's-complement signed. An 8-bit coefficient of 0x80 weights by −128.
- R7: Each product uses the coefficient value present on the edge where its sample was accepted. The output is therefore sum over k of coefA(n−k)[k]·x[n−k], where coefA(j) is the coefficient bus when sample j was accepted.
- R8: Full-range samples wrap: the output is the exact sum taken modulo 2^32, with no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 32 | Signed input sample |
| smp_in_vld | input | 1 | Input sample strobe |
| coef_bus | input | 15x8 (120) | Signed coefficients, entry k in bits 8k+7..8k |
| smp_out | output | 32 | Signed filtered sample |
| smp_out_vld | output | 1 | Output sample strobe |

## Verification
The assertions check three things on every cycle. The output strobe follows the input strobe one-for-one with a one-cycle delay. The output sample and the partial-sum registers do not move on idle cycles. The arithmetic can only be shown by the bench scenarios, which compare each output with a convolution kept in the bench: an impulse response, gapped arrivals, signed extremes, coefficient changes in mid-stream, full-range wraparound and a reset in mid-stream.

// File: rtl/xfir_pkg.sv
package xfir_pkg;
  localparam int unsigned TAPS   = 15;
  localparam int unsigned COEF_W = 8;
  localparam int unsigned SAMP_W = 32;
  localparam int unsigned PROD_W = SAMP_W + COEF_W;
  localparam int unsigned ACC_W  = PROD_W + $clog2(TAPS);

  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // Signed product of one sample and one coefficient (coefficient sign-extended).
  function automatic prod_t tap_mul(input logic signed [SAMP_W-1:0] x,
                                    input logic [COEF_W-1:0] c);
    prod_t xe;
    prod_t ce;
    xe = PROD_W'(x);
    ce = PROD_W'($signed(c));
    return xe * ce;
  endfunction

  // Add one product onto a partial sum at accumulator width.
  function automatic acc_t tap_add(input prod_t p, input acc_t s);
    acc_t pe;
    pe = ACC_W'(p);
    return pe + s;
  endfunction
endpackage

// File: rtl/xfir_mul_bank.sv
module xfir_mul_bank
  import xfir_pkg::*;
#(
  parameter int unsigned N_TAP = TAPS
) (
  input  logic signed [SAMP_W-1:0]            sample,
  input  logic        [N_TAP-1:0][COEF_W-1:0] coefs,
  output prod_t       [N_TAP-1:0]             prods
);
  // One multiplier per tap, all fed by the same incoming sample.
  for (genvar k = 0; k < N_TAP; k++) begin : g_mul
    assign prods[k] = tap_mul(sample, coefs[k]);
  end
endmodule

// File: rtl/xfir_sum_chain.sv
module xfir_sum_chain
  import xfir_pkg::*;
#(
  parameter int unsigned N_TAP = TAPS,
  localparam int unsigned N_REG = N_TAP - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  prod_t [N_TAP-1:0]      prods,
  output acc_t                   head
);
  acc_t [N_REG-1:0] sums;

  // Transposed chain: register k collects product k+1 plus the register behind it.
  for (genvar k = 0; k < N_REG; k++) begin : g_stage
    if (k == N_REG - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)      sums[k] <= '0;
        else if (adv) sums[k] <= ACC_W'(prods[k+1]);
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)      sums[k] <= '0;
        else if (adv) sums[k] <= tap_add(prods[k+1], sums[k+1]);
      end
    end
  end

  assign head = sums[0];

  // R4: with no accepted sample the partial sums stay frozen
  a_r4_chain_frozen: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(sums));
endmodule

// File: rtl/xpose_fir.sv
module xpose_fir
  import xfir_pkg::*;
#(
  parameter int unsigned N_TAP = TAPS
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic signed [SAMP_W-1:0]        smp_in,
  input  logic                            smp_in_vld,
  input  logic signed [N_TAP-1:0][COEF_W-1:0] coef_bus,
  output logic signed [SAMP_W-1:0]        smp_out,
  output logic                            smp_out_vld
);
  prod_t [N_TAP-1:0] prods;
  acc_t              head_sum;
  acc_t              full_sum;
  logic              accept;

  assign accept = smp_in_vld;

  xfir_mul_bank #(.N_TAP(N_TAP)) u_mul (
    .sample (smp_in),
    .coefs  (coef_bus),
    .prods  (prods)
  );

  xfir_sum_chain #(.N_TAP(N_TAP)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .adv   (accept),
    .prods (prods),
    .head  (head_sum)
  );

  assign full_sum = tap_add(prods[0], head_sum);

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_out     <= '0;
      smp_out_vld <= 1'b0;
    end else begin
      smp_out_vld <= accept;
      if (accept) smp_out <= full_sum[SAMP_W-1:0];
    end
  end

  // R3: every accepted sample yields a strobe one cycle later
  a_r3_vld_follows: assert property (@(posedge clk) disable iff (rst)
    smp_in_vld |=> smp_out_vld);
  // R3: no strobe without a sample one cycle earlier
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !smp_in_vld |=> !smp_out_vld);
  // R4: output sample held on idle cycles
  a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_in_vld |=> $stable(smp_out));
endmodule

// File: tb/xpose_fir_tb.sv
module xpose_fir_tb;
  localparam int NT = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [31:0] din = '0;
  logic dvld = 1'b0;
  logic [NT-1:0][7:0] cbus = '0;
  wire  signed [31:0] dout;
  wire  dv;

  always #2 clk = ~clk;

  xpose_fir u_dut (
    .clk(clk), .rst(rst), .smp_in(din), .smp_in_vld(dvld),
    .coef_bus(cbus), .smp_out(dout), .smp_out_vld(dv)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  longint hx [NT];
  logic [NT-1:0][7:0] hc [NT];
  logic [31:0] last_out = '0;

  function automatic longint cval(logic [NT-1:0][7:0] v, int k);
    logic signed [7:0] c;
    c = v[k];
    return longint'(c);
  endfunction

  // Convolution with the coefficients captured alongside each sample (R2, R7).
  function automatic logic [31:0] model_y();
    longint acc = 0;
    for (int k = 0; k < NT; k++) acc += cval(hc[k], k) * hx[k];
    return acc[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NT; k++) begin hx[k] = 0; hc[k] = '0; end
    last_out = '0;
  endtask

  // Called at a falling edge; drives one cycle and checks the result one edge later.
  task automatic push(bit v, logic signed [31:0] x, string tag);
    logic [31:0] exp;
    din = x; dvld = v;
    if (v) begin
      for (int k = NT-1; k > 0; k--) begin hx[k] = hx[k-1]; hc[k] = hc[k-1]; end
      hx[0] = longint'(x);
      hc[0] = cbus;
    end
    @(negedge clk);
    if (v) begin
      check({tag, " R3 strobe"}, {31'b0, dv}, 32'd1);
      exp = model_y();
      check(tag, dout, exp);
      last_out = exp;
    end else begin
      check("R3 idle strobe", {31'b0, dv}, 32'd0);
      check({tag, " held"}, dout, last_out);
    end
    dvld = 1'b0;
  endtask

  task automatic load(int c [NT]);
    for (int k = 0; k < NT; k++) cbus[k] = c[k][7:0];
  endtask

  function automatic logic signed [31:0] small_x();
    return 32'(int'($urandom_range(255)) - 128);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int lp [NT] = '{-2,-3,-4,0,9,21,32,36,32,21,9,0,-4,-3,-2};
    int hp [NT] = '{-3,14,-20,6,16,-5,-41,68,-41,-5,16,6,-20,14,-3};
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset strobe", {31'b0, dv}, 32'd0);
    check("R1 reset data", dout, 32'd0);
    rst = 1'b0;

    // R5/R2: impulse response reproduces the coefficients in order
    load(lp);
    push(1, 32'sd1, "R5 first sample");
    for (int i = 0; i < 18; i++) push(1, 32'sd0, "R2 impulse tail");

    // R4: sparse arrivals with junk on the data lines while idle
    for (int i = 0; i < 300; i++) begin
      bit v = ($urandom_range(3) == 0);
      push(v, v ? small_x() : 32'($urandom()), "R4 gapped");
    end
    for (int i = 0; i < 6; i++) push(0, 32'($urandom()), "R4 idle");

    // R6: signed extremes
    load(hp);
    for (int i = 0; i < 20; i++) push(1, small_x(), "R6 highpass");
    for (int k = 0; k < NT; k++) cbus[k] = 8'h80;
    for (int i = 0; i < 20; i++) push(1, (i % 2) ? -32'sd128 : 32'sd127, "R6 minus128");

    // R7: coefficients change mid-stream
    for (int i = 0; i < 200; i++) begin
      if (i % 7 == 0) for (int k = 0; k < NT; k++) cbus[k] = 8'($urandom());
      push($urandom_range(1) == 1, small_x(), "R7 live coef");
    end

    // R8: full-range samples wrap modulo 2^32
    for (int i = 0; i < 150; i++) begin
      if (i % 10 == 0) for (int k = 0; k < NT; k++) cbus[k] = 8'($urandom());
      push(1, 32'($urandom()), "R8 wrap");
    end

    // R1: reset in mid-stream discards history
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset strobe", {31'b0, dv}, 32'd0);
    check("R1 mid reset data", dout, 32'd0);
    rst = 1'b0;
    model_clear();
    push(1, -32'sd77, "R1 first after reset");
    for (int i = 0; i < 16; i++) push(1, small_x(), "R1 refill");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule